// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block brings a smart card's contacts up and down in a fixed, timed order. A host asks for a card session by pulling an active-low command line low. If a card is present and no fault is flagged, the sequencer starts the voltage pump and switches the slow housekeeping oscillator to its fast rate. It then steps through the card supply, data line release, card clock and card reset enables. Every step lands on a whole number of half-units. One unit is 64 oscillator periods, so a half-unit is 32 of them.

Shutdown runs the same schedule in reverse. It starts when the host releases the command, when a fault input asserts, or when the card is pulled out. In the last two cases the active-low status output drops and stays low until the host has released the command. The clock start can follow the reset-in line: if reset-in was high when the session began, the clock starts when reset-in falls after the data lines are released. This lets the host count clock pulses exactly before it drives card reset.

Top module: `card_power_seq`

## Requirements
- R1: Out of reset, and whenever no session is running, every enable output is low and `off_n_o` equals `present_i`.
- R2: A session starts only when `cmd_n_i` is low, `present_i` is high and no fault input is high. On the first clock edge that sees this, `pump_en_o` and `osc_fast_o` go high.
- R3: With the time counted from the session start in half-units h, `supply_en_o` rises at h = PUMP_HALVES and `data_en_o` rises at h = PUMP_HALVES + 8.
- R4: If `rstin_i` was low on the start edge, `card_clk_en_o` rises together with `data_en_o`.
- R5: If `rstin_i` was high on the start edge, `card_clk_en_o` rises in the first cycle after the data release point in which `rstin_i` is low. It rises no later than the reset point h = PUMP_HALVES + 14. Once risen, it stays high for the rest of the session.
- R6: Before the reset point, `card_rst_o` is low. From the reset point on, it equals `rstin_i`.
- R7: On shutdown, counting half-units d from the abort edge: `card_rst_o` drops at once, the clock drops at d = 1, the data lines at d = 2, the supply at d = 3, and the pump and fast oscillator at d = 10. An enable that was not yet on stays off.
- R8: A fault input or card removal during a session drives `off_n_o` low from the next edge and starts the shutdown of R7.
- R9: After a shutdown caused by a fault or by removal, no new session starts and `off_n_o` stays low until `cmd_n_i` is seen high.
- R10: One half-unit is TICKS_PER_HALF cycles with `osc_tick_i` high. Cycles without a tick do not advance the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle pulse per slow oscillator period |
| cmd_n_i | input | 1 | Session request, active low |
| rstin_i | input | 1 | Host request for card reset |
| present_i | input | 1 | Debounced card-present flag |
| fault_ocp_i | input | 1 | Card supply overcurrent |
| fault_hot_i | input | 1 | Overtemperature |
| fault_uv_i | input | 1 | Logic supply low |
| fault_pump_i | input | 1 | Pump out of range |
| pump_en_o | output | 1 | Voltage pump enable |
| osc_fast_o | output | 1 | Oscillator fast-rate select |
| supply_en_o | output | 1 | Card supply enable |
| data_en_o | output | 1 | Data lines released (low clamp off) |
| card_clk_en_o | output | 1 | Card clock gate enable |
| card_rst_o | output | 1 | Card reset contact level |
| off_n_o | output | 1 | Status/interrupt, active low |

## Verification
The bench builds the sequencer with TICKS_PER_HALF = 3 and keeps the default step offsets. A full power-up then takes 48 ticks and a shutdown 30, so hundreds of sessions, aborts at every step and lockouts fit into a short run. Ticks are withheld at random in most of the run, which exercises the tick-to-half-unit scaling of R10 without changing the step pattern.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_ON    = 3'd2,
    ST_DEACT = 3'd3,
    ST_LOCK  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_half_timer.sv
module seq_half_timer #(
  parameter int TICKS_PER_HALF = 32,
  parameter int HALF_W         = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  output logic [HALF_W-1:0] half_o
);
  localparam int TW = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
  localparam logic [TW-1:0]     TLAST = TW'(TICKS_PER_HALF - 1);
  localparam logic [HALF_W-1:0] HMAX  = '1;

  logic [TW-1:0]     tick_q;
  logic [HALF_W-1:0] half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      half_q <= '0;
    end else if (clear_i) begin
      tick_q <= '0;
      half_q <= '0;
    end else if (tick_i) begin
      if (tick_q == TLAST) begin
        tick_q <= '0;
        if (half_q != HMAX) half_q <= half_q + 1'b1;  // saturate
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign half_o = half_q;
endmodule

// File: rtl/seq_clk_gate.sv
module seq_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rstin_i,
  input  logic act_i,
  input  logic on_i,
  input  logic data_phase_i,
  input  logic rst_phase_i,
  output logic clk_en_o
);
  logic held_q, clk_on_q, go;

  // held at start: wait for reset-in to fall before releasing the clock
  assign go = !held_q || !rstin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= 1'b0;
      clk_on_q <= 1'b0;
    end else if (start_i) begin
      held_q   <= rstin_i;
      clk_on_q <= 1'b0;
    end else if (act_i && data_phase_i && go) begin
      clk_on_q <= 1'b1;
    end
  end

  assign clk_en_o = on_i || (act_i && (rst_phase_i || clk_on_q || (data_phase_i && go)));
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import card_seq_pkg::*;
#(
  parameter int TICKS_PER_HALF = 32,
  parameter int PUMP_HALVES    = 2,
  parameter int SUPPLY_HALVES  = 0,
  parameter int DATA_HALVES    = 8,
  parameter int RST_HALVES     = 14,
  parameter int DN_CLK_HALVES  = 1,
  parameter int DN_DATA_HALVES = 2,
  parameter int DN_SUP_HALVES  = 3,
  parameter int DN_PUMP_HALVES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic cmd_n_i,
  input  logic rstin_i,
  input  logic present_i,
  input  logic fault_ocp_i,
  input  logic fault_hot_i,
  input  logic fault_uv_i,
  input  logic fault_pump_i,
  output logic pump_en_o,
  output logic osc_fast_o,
  output logic supply_en_o,
  output logic data_en_o,
  output logic card_clk_en_o,
  output logic card_rst_o,
  output logic off_n_o
);
  localparam int ACT_SUP  = PUMP_HALVES + SUPPLY_HALVES;
  localparam int ACT_DATA = PUMP_HALVES + DATA_HALVES;
  localparam int ACT_RST  = PUMP_HALVES + RST_HALVES;
  localparam int HALF_TOP = (ACT_RST > DN_PUMP_HALVES) ? ACT_RST : DN_PUMP_HALVES;
  localparam int HALF_W   = $clog2(HALF_TOP + 2);

  localparam logic [HALF_W-1:0] H_SUP   = HALF_W'(ACT_SUP);
  localparam logic [HALF_W-1:0] H_DATA  = HALF_W'(ACT_DATA);
  localparam logic [HALF_W-1:0] H_RST   = HALF_W'(ACT_RST);
  localparam logic [HALF_W-1:0] H_DCLK  = HALF_W'(DN_CLK_HALVES);
  localparam logic [HALF_W-1:0] H_DDATA = HALF_W'(DN_DATA_HALVES);
  localparam logic [HALF_W-1:0] H_DSUP  = HALF_W'(DN_SUP_HALVES);
  localparam logic [HALF_W-1:0] H_DPUMP = HALF_W'(DN_PUMP_HALVES);

  seq_state_e        state_q, state_d;
  logic [HALF_W-1:0] half;
  logic              in_act, in_on, in_down;
  logic              any_fault, hard_req, abort_req, go_up, go_down;
  logic              fault_q;
  logic [2:0]        snap_q;  // {clk, data, supply} at abort
  logic              clk_live, data_live, sup_live;

  assign any_fault = fault_ocp_i | fault_hot_i | fault_uv_i | fault_pump_i;
  assign hard_req  = any_fault | !present_i;
  assign abort_req = cmd_n_i | hard_req;

  assign in_act  = (state_q == ST_ACT);
  assign in_on   = (state_q == ST_ON);
  assign in_down = (state_q == ST_DEACT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (!cmd_n_i && present_i && !any_fault) state_d = ST_ACT;
      ST_ACT:   if (abort_req) state_d = ST_DEACT;
                else if (half >= H_RST) state_d = ST_ON;
      ST_ON:    if (abort_req) state_d = ST_DEACT;
      ST_DEACT: if (half >= H_DPUMP) state_d = fault_q ? ST_LOCK : ST_IDLE;
      ST_LOCK:  if (cmd_n_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign go_up   = (state_q == ST_IDLE) && (state_d == ST_ACT);
  assign go_down = (in_act || in_on) && abort_req;

  seq_half_timer #(
    .TICKS_PER_HALF(TICKS_PER_HALF),
    .HALF_W        (HALF_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(go_up | go_down),
    .tick_i (osc_tick_i),
    .half_o (half)
  );

  seq_clk_gate u_clk_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go_up),
    .rstin_i     (rstin_i),
    .act_i       (in_act),
    .on_i        (in_on),
    .data_phase_i(half >= H_DATA),
    .rst_phase_i (half >= H_RST),
    .clk_en_o    (clk_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      if (go_down) begin
        snap_q  <= {clk_live, data_live, sup_live};
        fault_q <= hard_req;
      end else if (state_q == ST_LOCK && cmd_n_i) begin
        fault_q <= 1'b0;
      end
    end
  end

  assign sup_live  = in_on || (in_act && half >= H_SUP);
  assign data_live = in_on || (in_act && half >= H_DATA);

  assign pump_en_o     = in_act || in_on || (in_down && half < H_DPUMP);
  assign osc_fast_o    = pump_en_o;
  assign supply_en_o   = sup_live  || (in_down && snap_q[0] && half < H_DSUP);
  assign data_en_o     = data_live || (in_down && snap_q[1] && half < H_DDATA);
  assign card_clk_en_o = clk_live  || (in_down && snap_q[2] && half < H_DCLK);
  assign card_rst_o    = rstin_i && (in_on || (in_act && half >= H_RST));
  assign off_n_o       = present_i && !fault_q;
endmodule

// File: rtl/card_power_seq_chk.sv
module card_power_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_n_i,
  input logic present_i,
  input logic pump_en_o,
  input logic supply_en_o,
  input logic data_en_o,
  input logic card_clk_en_o,
  input logic card_rst_o,
  input logic off_n_o
);
  // R2
  pump_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> $past(!cmd_n_i && present_i));

  // R3
  data_needs_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> supply_en_o);

  // R7
  supply_needs_pump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_en_o |-> pump_en_o);

  // R4
  clk_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_clk_en_o |-> data_en_o);

  // R6
  rst_needs_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> card_clk_en_o);

  // R8
  fault_holds_rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_n_o && present_i) |-> !card_rst_o);

  // R7
  pump_last_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pump_en_o) |-> !supply_en_o && !data_en_o && !card_clk_en_o);
endmodule

bind card_power_seq card_power_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_n_i      (cmd_n_i),
  .present_i    (present_i),
  .pump_en_o    (pump_en_o),
  .supply_en_o  (supply_en_o),
  .data_en_o    (data_en_o),
  .card_clk_en_o(card_clk_en_o),
  .card_rst_o   (card_rst_o),
  .off_n_o      (off_n_o)
);

// File: tb/card_power_seq_tb.sv
module card_power_seq_tb;
  localparam int TPH    = 3;
  localparam int P      = 2;
  localparam int A_SUP  = P;
  localparam int A_DATA = P + 8;
  localparam int A_RST  = P + 14;
  localparam int D_CLK  = 1;
  localparam int D_DATA = 2;
  localparam int D_SUP  = 3;
  localparam int D_PUMP = 10;

  localparam int M_IDLE = 0, M_ACT = 1, M_ON = 2, M_DN = 3, M_LOCK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, cmd_n = 1'b1, rstin = 1'b0, pres = 1'b0;
  logic f_oc = 1'b0, f_hot = 1'b0, f_uv = 1'b0, f_pump = 1'b0;
  logic pump, oscf, sup, dat, cclk, crst, off_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_st = M_IDLE;
  int m_k = 0;
  bit m_held = 0, m_clkon = 0, m_fault = 0;
  bit s_clk = 0, s_dat = 0, s_sup = 0;

  always #2 clk = ~clk;

  card_power_seq #(
    .TICKS_PER_HALF(TPH), .PUMP_HALVES(P), .SUPPLY_HALVES(0), .DATA_HALVES(8),
    .RST_HALVES(14), .DN_CLK_HALVES(D_CLK), .DN_DATA_HALVES(D_DATA),
    .DN_SUP_HALVES(D_SUP), .DN_PUMP_HALVES(D_PUMP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .cmd_n_i(cmd_n),
    .rstin_i(rstin), .present_i(pres), .fault_ocp_i(f_oc), .fault_hot_i(f_hot),
    .fault_uv_i(f_uv), .fault_pump_i(f_pump), .pump_en_o(pump),
    .osc_fast_o(oscf), .supply_en_o(sup), .data_en_o(dat),
    .card_clk_en_o(cclk), .card_rst_o(crst), .off_n_o(off_n)
  );

  function automatic bit any_flt();
    return f_oc | f_hot | f_uv | f_pump;
  endfunction

  // expected {pump, osc, sup, dat, clk, rst}
  function automatic logic [5:0] exp_out();
    int h = m_k / TPH;
    case (m_st)
      M_ACT: return {1'b1, 1'b1, h >= A_SUP, h >= A_DATA,
                     (h >= A_RST) || m_clkon || (h >= A_DATA && (!m_held || !rstin)),
                     (h >= A_RST) && rstin};
      M_ON:  return {5'b11111, rstin};
      M_DN:  return {h < D_PUMP, h < D_PUMP, s_sup && h < D_SUP, s_dat && h < D_DATA,
                     s_clk && h < D_CLK, 1'b0};
      default: return 6'b0;
    endcase
  endfunction

  function automatic string tag_of(int idx);
    // idx: 0 pump,1 osc,2 sup,3 dat,4 clk,5 rst
    case (m_st)
      M_IDLE: return "R1";
      M_LOCK: return "R9";
      M_DN:   return "R7";
      M_ON:   return "R6";
      default: begin
        if (idx <= 1) return "R2";
        if (idx <= 3) return "R3 R10";
        if (idx == 4) return m_held ? "R5" : "R4";
        return "R6";
      end
    endcase
  endfunction

  task automatic chk(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [5:0] e = exp_out();
    chk(tag_of(0), "pump_en", pump, e[5]);
    chk(tag_of(1), "osc_fast", oscf, e[4]);
    chk(tag_of(2), "supply_en", sup, e[3]);
    chk(tag_of(3), "data_en", dat, e[2]);
    chk(tag_of(4), "card_clk_en", cclk, e[1]);
    chk(tag_of(5), "card_rst", crst, e[0]);
    chk(m_fault ? "R8 R9" : "R1", "off_n", off_n, pres && !m_fault);
  endtask

  task automatic model_edge();
    int h = m_k / TPH;
    bit hard = any_flt() || !pres;
    bit ab = cmd_n || hard;
    logic [5:0] e = exp_out();
    case (m_st)
      M_IDLE: if (!cmd_n && pres && !any_flt()) begin
        m_st = M_ACT; m_k = 0; m_held = rstin; m_clkon = 0;
      end
      M_ACT: if (ab) begin
        s_sup = e[3]; s_dat = e[2]; s_clk = e[1];
        m_st = M_DN; m_fault = hard; m_k = 0;
      end else begin
        if (h >= A_DATA && (!m_held || !rstin)) m_clkon = 1;
        if (h >= A_RST) m_st = M_ON;
        else if (tick) m_k++;
      end
      M_ON: if (ab) begin
        s_sup = 1; s_dat = 1; s_clk = 1;
        m_st = M_DN; m_fault = hard; m_k = 0;
      end
      M_DN: if (h >= D_PUMP) m_st = m_fault ? M_LOCK : M_IDLE;
            else if (tick) m_k++;
      default: if (cmd_n) begin m_st = M_IDLE; m_fault = 0; end
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    compare();  // R1 reset state
    rst_n = 1'b1;
    pres = 1'b1;
    run(3);     // R1 idle with card present
    // R2: refused without a card, and with a fault
    pres = 1'b0; cmd_n = 1'b0; run(10);
    pres = 1'b1; f_hot = 1'b1; run(5);
    cmd_n = 1'b1; f_hot = 1'b0; run(3);
    // R3 R4 R6 R7: plain session, reset-in low at start
    rstin = 1'b0; cmd_n = 1'b0; run(60);
    rstin = 1'b1; run(5); rstin = 1'b0; run(3); rstin = 1'b1; run(4);
    cmd_n = 1'b1; run(40);
    // R5: reset-in held high, falls after the data release point
    rstin = 1'b1; cmd_n = 1'b0; run(36);
    rstin = 1'b0; run(4); rstin = 1'b1; run(20);
    cmd_n = 1'b1; run(40);
    // R5 boundary: reset-in never falls, clock at the reset point
    rstin = 1'b1; cmd_n = 1'b0; run(60);
    // R8 R9: fault in an active session, lockout while command stays low
    f_oc = 1'b1; run(1); f_oc = 1'b0; run(70);
    cmd_n = 1'b1; run(4);
    // R8 R7: card pulled early in power-up, partial snapshot
    rstin = 1'b0; cmd_n = 1'b0; run(8);
    pres = 1'b0; run(40);
    pres = 1'b1; cmd_n = 1'b1; run(4);
    // R10: sparse ticks with random mixed stimulus
    for (int i = 0; i < 12000; i++) begin
      tick  = ($urandom % 4) != 0;
      if ($urandom % 150 == 0) cmd_n = ~cmd_n;
      if ($urandom % 40 == 0) rstin = ~rstin;
      if ($urandom % 600 == 0) pres = ~pres;
      f_oc   = ($urandom % 900 == 0);
      f_hot  = ($urandom % 1500 == 0);
      f_uv   = ($urandom % 1500 == 0);
      f_pump = ($urandom % 1500 == 0);
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule